// File: doc/BRIEF.md
# Two-Segment Base/Limit Address Relocator

This block sits between a processor and physical memory and turns each virtual address into a physical one according to the current privilege mode. In supervisor mode the address goes straight through, zero-extended to the physical width. There is no relocation and no bounds check in that mode.

In user mode the top virtual address bit picks one of two segments. Bit value 0 picks the low segment and 1 picks the high segment. The remaining bits form the in-segment offset. The offset is checked against that segment's length and then added to that segment's base. Each segment also carries its own read-only flag. A typical use keeps private writable data in the low segment and shared read-only code in the high segment. A writable shared high segment, or a read-only low segment, is also allowed.

A violating access issues no memory request. Instead it raises a one-cycle fault with a cause code. The segment settings are loaded through a configuration write port that only supervisor mode may use. Every accepted request returns its result exactly one cycle later.

Top module: `seg_relocator`

## Requirements
- R1: With `user_mode` low, a request produces `mem_valid` with `mem_addr` equal to `req_addr` zero-extended, and never faults, whatever the segment settings.
- R2: With `user_mode` high, `req_addr` bit VA_W-1 selects the segment (0 low, 1 high), and the low VA_W-1 bits are the offset.
- R3: A user access that is allowed produces `mem_addr` = selected base + offset, and `mem_write` equal to `req_write`.
- R4: A user access whose offset is not below the selected segment's length faults with `fault_cause` = 2'b01, and `mem_valid` stays low.
- R5: A user access where base + offset does not fit in PA_W bits faults with cause 2'b01.
- R6: A user write to a segment whose read-only flag is set faults with cause 2'b10. Reads of that segment succeed. When both a length fault and a protection fault apply, cause 2'b01 wins.
- R7: The read-only flag is held separately for each segment. Each segment can be either writable or read-only.
- R8: `mem_valid` or `fault` (exactly one of them) pulses for one cycle, in the cycle after a request is presented. With no request, both stay low and `fault_cause` is 2'b00.
- R9: A configuration write (`cfg_we`) made while `user_mode` is high changes no segment setting. It raises `cfg_denied` for one cycle in the next cycle.
- R10: After reset all bases and lengths are zero and both read-only flags are clear, so every user access faults with cause 2'b01. All outputs are low.
- R11: A supervisor configuration write governs a user request presented in the very next cycle. `cfg_sel` = 0 writes the low segment and 1 writes the high segment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| user_mode | input | 1 | 1 = user, 0 = supervisor |
| req_valid | input | 1 | Request present this cycle |
| req_addr | input | VA_W | Virtual address |
| req_write | input | 1 | 1 = write, 0 = read |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 1 | Segment to configure (0 low, 1 high) |
| cfg_base | input | PA_W | Base value to load |
| cfg_len | input | VA_W | Length value to load (0 to 2^(VA_W-1)) |
| cfg_ro | input | 1 | Read-only flag to load |
| mem_valid | output | 1 | Translated memory request |
| mem_addr | output | PA_W | Physical address |
| mem_write | output | 1 | Write flag of the memory request |
| fault | output | 1 | Access violation pulse |
| fault_cause | output | 2 | 01 length, 10 write-protect, 00 none |
| cfg_denied | output | 1 | Pulse after a configuration write attempted in user mode |

## Verification
The bench sweeps every virtual address, as both reads and writes, across several segment layouts in a narrow configuration. The targets are offsets at exactly the length and one below it, a zero length, and bases near the top of physical memory where the sum wraps. A design that compares with "greater than" instead of "greater or equal" would let the access at the length through. A design that drops the carry would return a small wrapped address instead of faulting. Read-only is tested on each segment in turn, which exposes a flag wired to the wrong segment or a wrong priority between the two causes. User-mode configuration attempts are followed by accesses that would reveal any change that got through. The supervisor sweep runs over zero lengths to show that no check leaks into that mode.

// File: rtl/seg_reloc_pkg.sv
package seg_reloc_pkg;
  typedef enum logic [1:0] {
    CAUSE_NONE = 2'b00,
    CAUSE_LEN  = 2'b01,
    CAUSE_WP   = 2'b10
  } fault_cause_e;

  localparam int unsigned NUM_SEGS = 2;
  localparam logic SEG_LOW  = 1'b0;
  localparam logic SEG_HIGH = 1'b1;
endpackage

// File: rtl/seg_cfg_bank.sv
module seg_cfg_bank
  import seg_reloc_pkg::*;
#(
  parameter int unsigned PA_W  = 20,
  parameter int unsigned LEN_W = 16
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            user_mode,
  input  logic                            cfg_we,
  input  logic                            cfg_sel,
  input  logic [PA_W-1:0]                 cfg_base,
  input  logic [LEN_W-1:0]                cfg_len,
  input  logic                            cfg_ro,
  output logic [NUM_SEGS-1:0][PA_W-1:0]   base_o,
  output logic [NUM_SEGS-1:0][LEN_W-1:0]  len_o,
  output logic [NUM_SEGS-1:0]             ro_o,
  output logic                            cfg_denied
);
  // Named events for the assertions below.
  logic write_granted;
  logic write_refused;
  logic denied_q;

  assign write_granted = cfg_we && !user_mode;
  assign write_refused = cfg_we && user_mode;

  for (genvar g = 0; g < NUM_SEGS; g++) begin : g_seg
    logic             hit;
    logic [PA_W-1:0]  base_r;
    logic [LEN_W-1:0] len_r;
    logic             ro_r;

    assign hit = write_granted && (cfg_sel == 1'(g));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        base_r <= '0;
        len_r  <= '0;
        ro_r   <= 1'b0;
      end else if (hit) begin
        base_r <= cfg_base;
        len_r  <= cfg_len;
        ro_r   <= cfg_ro;
      end
    end

    assign base_o[g] = base_r;
    assign len_o[g]  = len_r;
    assign ro_o[g]   = ro_r;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) denied_q <= 1'b0;
    else        denied_q <= write_refused;
  end
  assign cfg_denied = denied_q;

  // R9: a refused write leaves every segment setting untouched
  p_user_cfg_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
    write_refused |=> ($stable(base_o) && $stable(len_o) && $stable(ro_o)));

  // R9: a refused write is reported in the following cycle
  p_user_cfg_flagged_r9: assert property (@(posedge clk) disable iff (!rst_n)
    write_refused |=> cfg_denied);

  // R11: a granted write is visible in the next cycle
  p_cfg_lands_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (write_granted && !cfg_sel) |=> (len_o[0] == $past(cfg_len)));
endmodule

// File: rtl/seg_xlate.sv
module seg_xlate
  import seg_reloc_pkg::*;
#(
  parameter int unsigned VA_W = 16,
  parameter int unsigned PA_W = 20,
  localparam int unsigned OFF_W = VA_W - 1,
  localparam int unsigned LEN_W = VA_W
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            user_mode,
  input  logic [VA_W-1:0]                 vaddr,
  input  logic                            is_write,
  input  logic [NUM_SEGS-1:0][PA_W-1:0]   base_i,
  input  logic [NUM_SEGS-1:0][LEN_W-1:0]  len_i,
  input  logic [NUM_SEGS-1:0]             ro_i,
  output logic [PA_W-1:0]                 paddr,
  output fault_cause_e                    cause
);
  // Relocation with carry out: bit PA_W set means the sum left the space.
  function automatic logic [PA_W:0] reloc_sum(input logic [PA_W-1:0] base,
                                              input logic [OFF_W-1:0] off);
    return {1'b0, base} + (PA_W+1)'(off);
  endfunction

  function automatic logic below_len(input logic [OFF_W-1:0] off,
                                     input logic [LEN_W-1:0] len);
    return LEN_W'(off) < len;
  endfunction

  logic             seg_sel;
  logic [OFF_W-1:0] offset;
  logic [PA_W:0]    sum;
  logic             len_viol;
  logic             ovf_viol;
  logic             wp_viol;

  assign seg_sel  = vaddr[VA_W-1];
  assign offset   = vaddr[OFF_W-1:0];
  assign sum      = reloc_sum(base_i[seg_sel], offset);
  assign len_viol = !below_len(offset, len_i[seg_sel]);
  assign ovf_viol = sum[PA_W];
  assign wp_viol  = is_write && ro_i[seg_sel];

  always_comb begin
    if (!user_mode) begin
      paddr = PA_W'(vaddr);
      cause = CAUSE_NONE;
    end else begin
      paddr = sum[PA_W-1:0];
      if (len_viol || ovf_viol) cause = CAUSE_LEN;
      else if (wp_viol)         cause = CAUSE_WP;
      else                      cause = CAUSE_NONE;
    end
  end

  // R6: a length problem always outranks a protection problem
  p_len_priority_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (user_mode && wp_viol && len_viol) |-> (cause == CAUSE_LEN));

  // R1: supervisor mode never reports a fault
  p_super_no_fault_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !user_mode |-> (cause == CAUSE_NONE));
endmodule

// File: rtl/seg_relocator.sv
module seg_relocator
  import seg_reloc_pkg::*;
#(
  parameter int unsigned VA_W = 16,
  parameter int unsigned PA_W = 20
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            user_mode,
  input  logic            req_valid,
  input  logic [VA_W-1:0] req_addr,
  input  logic            req_write,
  input  logic            cfg_we,
  input  logic            cfg_sel,
  input  logic [PA_W-1:0] cfg_base,
  input  logic [VA_W-1:0] cfg_len,
  input  logic            cfg_ro,
  output logic            mem_valid,
  output logic [PA_W-1:0] mem_addr,
  output logic            mem_write,
  output logic            fault,
  output logic [1:0]      fault_cause,
  output logic            cfg_denied
);
  localparam int unsigned LEN_W = VA_W;

  logic [NUM_SEGS-1:0][PA_W-1:0]  seg_base;
  logic [NUM_SEGS-1:0][LEN_W-1:0] seg_len;
  logic [NUM_SEGS-1:0]            seg_ro;
  logic [PA_W-1:0]                xl_addr;
  fault_cause_e                   xl_cause;
  logic                           accept_ok;
  logic                           accept_bad;

  seg_cfg_bank #(.PA_W(PA_W), .LEN_W(LEN_W)) u_cfg (
    .clk        (clk),
    .rst_n      (rst_n),
    .user_mode  (user_mode),
    .cfg_we     (cfg_we),
    .cfg_sel    (cfg_sel),
    .cfg_base   (cfg_base),
    .cfg_len    (cfg_len),
    .cfg_ro     (cfg_ro),
    .base_o     (seg_base),
    .len_o      (seg_len),
    .ro_o       (seg_ro),
    .cfg_denied (cfg_denied)
  );

  seg_xlate #(.VA_W(VA_W), .PA_W(PA_W)) u_xlate (
    .clk       (clk),
    .rst_n     (rst_n),
    .user_mode (user_mode),
    .vaddr     (req_addr),
    .is_write  (req_write),
    .base_i    (seg_base),
    .len_i     (seg_len),
    .ro_i      (seg_ro),
    .paddr     (xl_addr),
    .cause     (xl_cause)
  );

  assign accept_ok  = req_valid && (xl_cause == CAUSE_NONE);
  assign accept_bad = req_valid && (xl_cause != CAUSE_NONE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mem_valid   <= 1'b0;
      mem_addr    <= '0;
      mem_write   <= 1'b0;
      fault       <= 1'b0;
      fault_cause <= CAUSE_NONE;
    end else begin
      mem_valid   <= accept_ok;
      mem_addr    <= accept_ok ? xl_addr : '0;
      mem_write   <= accept_ok && req_write;
      fault       <= accept_bad;
      fault_cause <= accept_bad ? xl_cause : CAUSE_NONE;
    end
  end

  // R4: a faulting access never reaches memory
  p_no_mem_on_fault_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_valid && fault));

  // R8: every request gets exactly one response one cycle later
  p_one_cycle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> (mem_valid ^ fault));

  // R8: no request, no response
  p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> (!mem_valid && !fault && fault_cause == 2'b00));

  // R1: supervisor requests pass through unchanged
  p_super_pass_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !user_mode) |=> (mem_valid && mem_addr == PA_W'($past(req_addr))));

  // R6: a reported cause is a single known code
  p_cause_code_r6: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> ($countones(fault_cause) == 1));
endmodule

// File: tb/seg_relocator_tb.sv
module seg_relocator_tb;
  localparam int VA_W = 5;
  localparam int PA_W = 6;
  localparam int OFF_N = 1 << (VA_W - 1);
  localparam int PA_N = 1 << PA_W;
  localparam time CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic user_mode = 1'b0, req_valid = 1'b0, req_write = 1'b0;
  logic [VA_W-1:0] req_addr = '0;
  logic cfg_we = 1'b0, cfg_sel = 1'b0, cfg_ro = 1'b0;
  logic [PA_W-1:0] cfg_base = '0;
  logic [VA_W-1:0] cfg_len = '0;
  logic mem_valid, mem_write, fault, cfg_denied;
  logic [PA_W-1:0] mem_addr;
  logic [1:0] fault_cause;

  int checks = 0;
  int errors = 0;
  int m_base[2];
  int m_len[2];
  bit m_ro[2];

  always #(CLK_PERIOD/2) clk = ~clk;

  seg_relocator #(.VA_W(VA_W), .PA_W(PA_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .user_mode(user_mode), .req_valid(req_valid),
    .req_addr(req_addr), .req_write(req_write), .cfg_we(cfg_we),
    .cfg_sel(cfg_sel), .cfg_base(cfg_base), .cfg_len(cfg_len), .cfg_ro(cfg_ro),
    .mem_valid(mem_valid), .mem_addr(mem_addr), .mem_write(mem_write),
    .fault(fault), .fault_cause(fault_cause), .cfg_denied(cfg_denied)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // Packs the response as {valid, fault, cause, write, addr}.
  function automatic int pack_resp(bit v, bit f, int c, bit w, int a);
    return (int'(v) << 12) | (int'(f) << 11) | (c << 9) | (int'(w) << 8) | a;
  endfunction

  task automatic do_cfg(input bit sel, input int b, input int l, input bit r,
                        input bit um, input string req);
    @(negedge clk);
    user_mode = um; cfg_we = 1'b1; cfg_sel = sel;
    cfg_base = PA_W'(b); cfg_len = VA_W'(l); cfg_ro = r;
    @(posedge clk);
    @(negedge clk);
    cfg_we = 1'b0;
    check(cfg_denied == um, req, cfg_denied, um);
    if (!um) begin
      m_base[sel] = b; m_len[sel] = l; m_ro[sel] = r;
    end
  endtask

  task automatic do_req(input int a, input bit wr, input bit um, input string req);
    int seg, off, sum, exp, act;
    seg = (a >> (VA_W - 1)) & 1;
    off = a & (OFF_N - 1);
    sum = m_base[seg] + off;
    if (!um)                                  exp = pack_resp(1, 0, 0, wr, a);
    else if (off >= m_len[seg] || sum >= PA_N) exp = pack_resp(0, 1, 1, 0, 0);
    else if (wr && m_ro[seg])                  exp = pack_resp(0, 1, 2, 0, 0);
    else                                       exp = pack_resp(1, 0, 0, wr, sum);
    @(negedge clk);
    user_mode = um; req_valid = 1'b1; req_addr = VA_W'(a); req_write = wr;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    act = pack_resp(mem_valid, fault, int'(fault_cause), mem_write, int'(mem_addr));
    check(act == exp, req, act, exp);
  endtask

  task automatic sweep_user(input string req);
    for (int a = 0; a < (1 << VA_W); a++)
      for (int w = 0; w < 2; w++)
        do_req(a, w[0], 1'b1, req);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=0x0 expected=0x1");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int s = 0; s < 2; s++) begin m_base[s] = 0; m_len[s] = 0; m_ro[s] = 0; end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R10: outputs low after reset
    check({mem_valid, fault, fault_cause, cfg_denied} == 5'b0, "R10 reset outputs",
          {mem_valid, fault, fault_cause, cfg_denied}, 0);
    // R10: zero lengths make every user access fault
    sweep_user("R10 reset lengths");
    // R1: supervisor passes through even with zero lengths
    for (int a = 0; a < (1 << VA_W); a++) do_req(a, a[0], 1'b0, "R1 supervisor pass");

    // R2 R3 R4 R6: low writable, high read-only shared
    do_cfg(1'b0, 10, 12, 1'b0, 1'b0, "R11 cfg low");
    do_req(5, 1'b0, 1'b1, "R11 next-cycle use");
    do_cfg(1'b1, 40, 16, 1'b1, 1'b0, "R11 cfg high");
    sweep_user("R2 R3 R4 R6 layout A");

    // R7 R5: low read-only, high writable and near top (wraps from offset 8)
    do_cfg(1'b0, 0, 16, 1'b1, 1'b0, "R7 cfg low ro");
    do_cfg(1'b1, 56, 16, 1'b0, 1'b0, "R7 cfg high rw");
    sweep_user("R5 R7 layout B");

    // R4: zero length on high, length one on low; sum ending exactly at top
    do_cfg(1'b0, 63, 1, 1'b0, 1'b0, "R4 cfg low len1");
    do_cfg(1'b1, 3, 0, 1'b0, 1'b0, "R4 cfg high len0");
    sweep_user("R4 R5 layout C");

    // R9: user-mode writes are refused and leave settings unchanged
    do_cfg(1'b0, 20, 16, 1'b1, 1'b1, "R9 refused low");
    do_cfg(1'b1, 0, 16, 1'b1, 1'b1, "R9 refused high");
    sweep_user("R9 unchanged after refused writes");

    // R8: idle cycle gives no response
    @(negedge clk);
    check({mem_valid, fault, fault_cause, cfg_denied} == 5'b0, "R8 idle quiet",
          {mem_valid, fault, fault_cause, cfg_denied}, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule